// File: doc/BRIEF.md
# Flow-Through Late-Write Synchronous SRAM

This block is a synthesizable model of a synchronous burst SRAM whose reads are flow-through and whose writes take their data one clock after the address. Because a write's data phase overlaps whatever access is issued next, the host can put a read, a write or a deselect on every consecutive clock. It never has to insert an idle cycle when the bus turns from writing to reading.

Every control input and the address are registered on the rising clock edge. The edges only count when the active-low clock enable is low. A read presents the selected word on the output within the same cycle as its registered address. A write leaves the output undriven and captures the data word one enabled edge later, updating only the byte lanes picked by the write selects. A burst sequencer walks the two low address bits for up to four beats, in either linear or interleaved order. The data bus is split into an input word, an output word and a drive flag, so the block contains no tristate nets.

A small write buffer holds the most recent write until the next enabled edge. Reads that hit it receive its selected lanes merged over the stored word.

Top module: `ft_sram`

## Requirements
- R1: While `clk_en_n` is high at a rising edge, that edge changes nothing. A pending write is not captured, the burst position is kept, and `dout`/`dout_en` keep their values.
- R2: An access starts only at an edge with `clk_en_n` low, `ld_n` low, `cs0_n` low, `cs1` high and `cs2_n` low. If `ld_n` is low and any select is inactive, the edge is a deselect and `dout_en` is low in the following cycle.
- R3: After an edge that starts a read (`we_n` high), `dout` carries the word at the registered address in that same cycle. `dout_en` follows `!oe_n` asynchronously during that cycle.
- R4: After an edge that starts a write (`we_n` low), `dout_en` stays low whatever `oe_n` is. The write data is taken from `din` at the next enabled edge.
- R5: Lane i covers `din[9*i+8:9*i]`. At the data edge it is written only when `bw_n[i]` is 0 at the address edge of that beat; other lanes keep their contents.
- R6: Accesses may be issued on every consecutive enabled edge. A read issued at the edge that captures a write's data returns the newly written lanes.
- R7: `ld_n` high at an enabled edge advances the burst. With `burst_mode`=0, beat k uses low address bits (a+k) mod 4, wrapping.
- R8: With `burst_mode`=1, beat k uses low address bits a XOR k.
- R9: A burst keeps the read/write type set at its load edge, and every write beat captures its own data. Advancing after a deselect leaves the block deselected.
- R10: After synchronous reset (`rst_n` low at an edge), `dout_en` is low and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low: load address / start access; high: advance burst |
| we_n | input | 1 | Low: write, high: read (sampled at load) |
| bw_n | input | LANES | Byte lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_mode | input | 1 | 0 linear, 1 interleaved burst order |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Output drive flag |

## Verification
The properties check, on every cycle, the rules that follow from the control pins alone. These are: an ignored edge holds the output, a deselect or a write start leaves the bus undriven, a read start drives it exactly when output enable is low, and reset idles the bus. Data correctness is left to the bench, which compares against its own model of the array. That model covers lane masking, forwarding of a just-captured write, the two burst orders with wrap-around, write bursts and data capture delayed across held clocks.

// File: rtl/ft_sram_pkg.sv
package ft_sram_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;
endpackage

// File: rtl/ft_sram_burst.sv
// Burst position: base low bits plus a beat counter; order picked by mode pin.
module ft_sram_burst #(
   parameter int BURST_BITS = 2
) (
   input  logic                  clk,
   input  logic                  step,
   input  logic                  load,
   input  logic                  interleave,
   input  logic [BURST_BITS-1:0] base_in,
   output logic [BURST_BITS-1:0] cur_low
);
   logic [BURST_BITS-1:0] base_q;
   logic [BURST_BITS-1:0] beat_q;

   always_ff @(posedge clk) begin
      if (step) begin
         if (load) begin
            base_q <= base_in;
            beat_q <= '0;
         end else begin
            beat_q <= beat_q + 1'b1;
         end
      end
   end

   always_comb begin
      if (interleave) cur_low = base_q ^ beat_q;
      else            cur_low = base_q + beat_q;
   end
endmodule

// File: rtl/ft_sram_ctrl.sv
// Access register: operation type, upper address, lane selects.
module ft_sram_ctrl
   import ft_sram_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int BURST_BITS = 2,
   parameter int LANES      = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         step,
   input  logic                         load,
   input  logic                         selected,
   input  logic                         we_n,
   input  logic [LANES-1:0]             bw_n,
   input  logic [ADDR_W-1:BURST_BITS]   addr_hi,
   output op_e                          op_q,
   output logic [ADDR_W-1:BURST_BITS]   hi_q,
   output logic [LANES-1:0]             lane_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q <= OP_NONE;
      end else if (step && load) begin
         if (!selected) op_q <= OP_NONE;
         else if (we_n) op_q <= OP_RD;
         else           op_q <= OP_WR;
      end
   end

   always_ff @(posedge clk) begin
      if (step) begin
         lane_q <= ~bw_n;
         if (load) hi_q <= addr_hi;
      end
   end
endmodule

// File: rtl/ft_sram_store.sv
// Lane-split array with a one-entry late-write buffer and read merge.
module ft_sram_store #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      step,
   input  logic                      capture,
   input  logic [ADDR_W-1:0]         cur_addr,
   input  logic [LANES-1:0]          lane_sel,
   input  logic [LANES*LANE_W-1:0]   wdata,
   output logic [LANES*LANE_W-1:0]   rdata
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int DATA_W = LANES * LANE_W;

   logic                wb_v;
   logic [ADDR_W-1:0]   wb_addr;
   logic [DATA_W-1:0]   wb_data;
   logic [LANES-1:0]    wb_lane;
   logic                hit;

   always_ff @(posedge clk) begin
      if (!rst_n)    wb_v <= 1'b0;
      else if (step) wb_v <= capture;
   end

   always_ff @(posedge clk) begin
      if (step && capture) begin
         wb_addr <= cur_addr;
         wb_data <= wdata;
         wb_lane <= lane_sel;
      end
   end

   assign hit = wb_v && (wb_addr == cur_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (step && wb_v && wb_lane[g])
            cells[wb_addr] <= wb_data[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = (hit && wb_lane[g]) ?
         wb_data[g*LANE_W +: LANE_W] : cells[cur_addr];
   end
endmodule

// File: rtl/ft_sram.sv
module ft_sram
   import ft_sram_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int LANES      = 4,
   parameter int LANE_W     = 9,
   parameter int BURST_BITS = 2,
   localparam int DATA_W    = LANES * LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_en_n,
   input  logic               cs0_n,
   input  logic               cs1,
   input  logic               cs2_n,
   input  logic               ld_n,
   input  logic               we_n,
   input  logic [LANES-1:0]   bw_n,
   input  logic               oe_n,
   input  logic               burst_mode,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  din,
   output logic [DATA_W-1:0]  dout,
   output logic               dout_en
);
   if (BURST_BITS < 1 || BURST_BITS >= ADDR_W) begin : g_bad_burst
      $error("ft_sram: BURST_BITS must be in 1..ADDR_W-1");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("ft_sram: LANES and LANE_W must be positive");
   end
   if (ADDR_W > 12) begin : g_bad_depth
      $error("ft_sram: ADDR_W above 12 is too deep for this model");
   end

   logic                        step;
   logic                        load;
   logic                        selected;
   op_e                         op_q;
   logic [ADDR_W-1:BURST_BITS]  hi_q;
   logic [LANES-1:0]            lane_q;
   logic [BURST_BITS-1:0]       cur_low;
   logic [ADDR_W-1:0]           cur_addr;

   assign step     = !clk_en_n;
   assign load     = !ld_n;
   assign selected = !cs0_n && cs1 && !cs2_n;

   ft_sram_ctrl #(
      .ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS), .LANES(LANES)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .step(step), .load(load),
      .selected(selected), .we_n(we_n), .bw_n(bw_n),
      .addr_hi(addr[ADDR_W-1:BURST_BITS]),
      .op_q(op_q), .hi_q(hi_q), .lane_q(lane_q)
   );

   ft_sram_burst #(.BURST_BITS(BURST_BITS)) u_burst (
      .clk(clk), .step(step), .load(load), .interleave(burst_mode),
      .base_in(addr[BURST_BITS-1:0]), .cur_low(cur_low)
   );

   assign cur_addr = {hi_q, cur_low};

   ft_sram_store #(
      .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .step(step),
      .capture(op_q == OP_WR), .cur_addr(cur_addr),
      .lane_sel(lane_q), .wdata(din), .rdata(dout)
   );

   assign dout_en = (op_q == OP_RD) && !oe_n;
endmodule

// File: rtl/ft_sram_chk.sv
module ft_sram_chk #(
   parameter int DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en_n,
   input logic              cs0_n,
   input logic              cs1,
   input logic              cs2_n,
   input logic              ld_n,
   input logic              we_n,
   input logic              oe_n,
   input logic              burst_mode,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en
);
   logic start_ok;
   assign start_ok = !clk_en_n && !ld_n && !cs0_n && cs1 && !cs2_n;

   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> ($stable(dout) || !$stable(burst_mode)));

   a_r2_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !ld_n && !(!cs0_n && cs1 && !cs2_n)) |=> !dout_en);

   a_r3_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && we_n) |=> (dout_en == !oe_n));

   a_r3_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> !oe_n);

   a_r4_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && !we_n) |=> !dout_en);

   a_r10_reset_idle: assert property (@(posedge clk)
      !rst_n |=> !dout_en);
endmodule

bind ft_sram ft_sram_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs0_n(cs0_n),
   .cs1(cs1), .cs2_n(cs2_n), .ld_n(ld_n), .we_n(we_n), .oe_n(oe_n),
   .burst_mode(burst_mode), .dout(dout), .dout_en(dout_en)
);

// File: tb/ft_sram_bench.sv
`timescale 1ns/1ps
module ft_sram_bench;
   localparam int AW = 8;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int DW = NL * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en_n = 1'b0;
   logic          cs0_n = 1'b1;
   logic          cs1 = 1'b0;
   logic          cs2_n = 1'b1;
   logic          ld_n = 1'b0;
   logic          we_n = 1'b1;
   logic [NL-1:0] bw_n = '1;
   logic          oe_n = 1'b1;
   logic          burst_mode = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   int total = 0;
   int bad = 0;

   // bench reference state
   logic [DW-1:0] ref_mem [1<<AW];
   int            m_op = 0;        // 0 none, 1 read, 2 write
   logic [AW-1:0] m_addr = '0;
   logic [1:0]    m_beat = '0;
   logic [NL-1:0] m_lane = '0;

   always #10 clk = ~clk;

   ft_sram u_ft_sram (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs0_n(cs0_n),
      .cs1(cs1), .cs2_n(cs2_n), .ld_n(ld_n), .we_n(we_n), .bw_n(bw_n),
      .oe_n(oe_n), .burst_mode(burst_mode), .addr(addr), .din(din),
      .dout(dout), .dout_en(dout_en)
   );

   function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] a, logic [1:0] k, logic mode);
      logic [1:0] lo;
      lo = mode ? (a[1:0] ^ k) : (a[1:0] + k);
      return {a[AW-1:2], lo};
   endfunction

   task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // one clock: off selects which chip select is inactive (0 = all active)
   task automatic cyc(logic cen, int off, logic ld, logic we, logic [NL-1:0] bw,
                      logic [AW-1:0] a, logic oe, string tag);
      logic [63:0] r;
      logic [AW-1:0] ea;
      @(negedge clk);
      r = {$urandom(), $urandom()};
      clk_en_n = cen; cs0_n = (off == 1); cs1 = (off != 2); cs2_n = (off == 3);
      ld_n = ld; we_n = we; bw_n = bw; addr = a; oe_n = oe; din = r[DW-1:0];
      @(posedge clk);
      if (!cen) begin
         if (m_op == 2) begin
            ea = beat_addr(m_addr, m_beat, burst_mode);
            for (int l = 0; l < NL; l++)
               if (m_lane[l]) ref_mem[ea][l*LW +: LW] = din[l*LW +: LW];
         end
         m_lane = ~bw;
         if (!ld) begin
            m_op = (off != 0) ? 0 : (we ? 1 : 2);
            m_addr = a;
            m_beat = 2'd0;
         end else begin
            m_beat = m_beat + 2'd1;
         end
      end
      #2;
      check(tag, {35'd0, dout_en}, {35'd0, (m_op == 1) && !oe});
      if (m_op == 1 && !oe)
         check(tag, dout, ref_mem[beat_addr(m_addr, m_beat, burst_mode)]);
   endtask

   initial begin
      #(20.0 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #2;
      check("R10 reset", {35'd0, dout_en}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      oe_n = 1'b0;
      @(posedge clk);
      #2;
      check("R10 idle after reset", {35'd0, dout_en}, '0);

      // fill the whole array back to back (R4 / R6)
      for (int i = 0; i < (1 << AW); i++)
         cyc(0, 0, 0, 0, 4'h0, i[AW-1:0], 0, "R4 write no drive");
      cyc(0, 1, 0, 1, 4'hF, 8'h00, 0, "R2 deselect");

      // single reads and async output enable (R3)
      for (int i = 0; i < 6; i++) begin
         cyc(0, 0, 0, 1, 4'hF, 8'h10 + 8'(i * 7), 0, "R3 read");
         oe_n = 1'b1; #1;
         check("R3 oe async off", {35'd0, dout_en}, '0);
         oe_n = 1'b0; #1;
         check("R3 oe async on", {35'd0, dout_en}, 36'd1);
      end
      cyc(0, 0, 0, 1, 4'hF, 8'h33, 1, "R3 read oe high");

      // byte lanes (R5)
      cyc(0, 0, 0, 0, 4'b0101, 8'h50, 0, "R5 lane write");
      cyc(0, 0, 0, 0, 4'b1110, 8'h51, 0, "R5 lane write");
      cyc(0, 0, 0, 1, 4'hF, 8'h50, 0, "R5 lane read");
      cyc(0, 0, 0, 1, 4'hF, 8'h51, 0, "R5 lane read");
      cyc(0, 0, 0, 0, 4'hF, 8'h52, 0, "R5 no lane write");
      cyc(0, 0, 0, 1, 4'hF, 8'h52, 0, "R5 unchanged read");

      // write then read same address immediately, alternating (R6)
      for (int i = 0; i < 8; i++) begin
         cyc(0, 0, 0, 0, 4'(i), 8'h60 + 8'(i), 0, "R6 write");
         cyc(0, 0, 0, 1, 4'hF, 8'h60 + 8'(i), 0, "R6 forward read");
      end

      // held clocks (R1)
      cyc(0, 0, 0, 1, 4'hF, 8'h61, 0, "R1 read");
      for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 4'h0, 8'h99, 0, "R1 held");
      cyc(0, 0, 0, 0, 4'h0, 8'h70, 0, "R1 write");
      for (int i = 0; i < 3; i++) cyc(1, 2, 1, 1, 4'h0, 8'h00, 0, "R1 held write");
      cyc(0, 0, 0, 1, 4'hF, 8'h70, 0, "R1 delayed capture");

      // deselect by each select, then advance stays off (R2, R9)
      for (int k = 1; k <= 3; k++) begin
         cyc(0, k, 0, 1, 4'hF, 8'h20, 0, "R2 deselect");
         cyc(0, 0, 1, 1, 4'hF, 8'h20, 0, "R9 advance deselected");
      end

      // linear burst with wrap (R7)
      burst_mode = 1'b0;
      cyc(0, 0, 0, 1, 4'hF, 8'h16, 0, "R7 linear");
      for (int i = 0; i < 4; i++) cyc(0, 3, 1, 0, 4'h0, 8'h00, 0, "R7 linear");
      // interleaved burst (R8)
      burst_mode = 1'b1;
      cyc(0, 0, 0, 1, 4'hF, 8'h25, 0, "R8 interleave");
      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 4'h0, 8'h00, 0, "R8 interleave");
      cyc(0, 0, 0, 1, 4'hF, 8'h27, 0, "R8 interleave");
      for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 4'h0, 8'h00, 0, "R8 interleave");
      // write burst then read back (R9)
      burst_mode = 1'b0;
      cyc(0, 0, 0, 0, 4'h0, 8'h42, 0, "R9 write burst");
      for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, 4'h0, 8'h00, 0, "R9 write burst");
      cyc(0, 0, 0, 1, 4'hF, 8'h40, 0, "R9 read burst");
      for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 4'hF, 8'h00, 0, "R9 read burst");

      // constrained random mix (R6)
      for (int seg = 0; seg < 2; seg++) begin
         cyc(0, 1, 0, 1, 4'hF, 8'h00, 0, "R2 segment");
         burst_mode = seg[0];
         for (int i = 0; i < 1500; i++) begin
            logic cen;
            int off;
            cen = ($urandom_range(9) == 0);
            off = ($urandom_range(9) == 0) ? int'($urandom_range(3, 1)) : 0;
            cyc(cen, off, ($urandom_range(9) < 3), $urandom_range(1) == 1,
                4'($urandom()), 8'($urandom()), ($urandom_range(9) < 2), "R6 random");
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule